// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block runs single read and write cycles on an external memory bus. The low address byte and the data byte share one set of lines. A separate port carries the high address byte. Four control outputs complete the bus:

- an active-low address strobe;
- an active-low data strobe;
- a read/write level;
- a space select that picks data memory or program memory.

The host side presents a request with a 16-bit address, a direction, a space select, write data and a wait-state count. A read returns its byte together with a one-clock completion pulse.

Every cycle follows a fixed order, and each phase is counted in system clocks:

1. Address setup.
2. Address strobe low.
3. Address hold after the strobe rises.
4. A turnaround clock. On a read the shared lines are released. On a write they change to the write byte.
5. Data strobe low. This phase is longer for reads than for writes, and each wait state adds one clock to it.
6. A hold clock after the data strobe rises.
7. Recovery.

The shared lines are modelled as separate output, output-enable and input signals, so the pad ring can build the tri-state buffer.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: After reset and whenever the block is not busy: both strobes are high, `rd_wr_n` is high, `ad_oe` is low, and `busy` and `done` are low.
- R2: A request is accepted at a clock edge where `req_valid` is high and `busy` is low. From the following cycle `hi_addr` holds `req_addr[15:8]` and `data_space` holds `req_dmem` (1 = data memory). Both stay unchanged until the cycle ends. `ad_out` carries `req_addr[7:0]` with `ad_oe` high from the first busy cycle until one clock after the address strobe rises.
- R3: `busy` rises in the cycle after acceptance. `addr_stb_n` then stays high for SETUP_CLK clocks and goes low for AS_CLK clocks. `rd_wr_n` is low for a write and high for a read, and it is stable for the whole busy period.
- R4: The two strobes are never low together. One clock after the address strobe rises, the shared lines are released for a read, or driven with the write byte for a write. This happens one clock before the data strobe falls.
- R5: On a read, `ad_oe` stays low while `data_stb_n` is low. `rdata` takes the value of `ad_in` from the last clock with the data strobe low. `done` is high for exactly one clock, the clock in which the data strobe has just risen.
- R6: On a write, `ad_out` carries `req_wdata` with `ad_oe` high from one clock before the data strobe falls to one clock after it rises. `rdata` keeps its previous value.
- R7: The data strobe stays low for RD_DS_CLK + w clocks on a read and for WR_DS_CLK + w clocks on a write. Here w is `wait_cfg` (0 to 3) sampled at acceptance. Later changes to `wait_cfg` have no effect on the running cycle.
- R8: After the data strobe rises, `busy` stays high for 1 + RECOV_CLK clocks. The total busy time is therefore SETUP_CLK + AS_CLK + 3 + data-strobe length + RECOV_CLK clocks.
- R9: `req_valid` is ignored while `busy` is high. Each accepted request produces exactly one address strobe pulse and one `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe from the host |
| req_addr | input | 16 | Cycle address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dmem | input | 1 | 1 = data memory space, 0 = program space |
| req_wdata | input | 8 | Write byte |
| wait_cfg | input | 2 | Wait states to add to the data strobe |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Last byte read |
| hi_addr | output | 8 | High address byte port |
| data_space | output | 1 | Space select, 1 = data memory |
| ad_out | output | 8 | Shared address/data lines, output value |
| ad_oe | output | 1 | Output enable for the shared lines |
| ad_in | input | 8 | Shared address/data lines, input value |
| addr_stb_n | output | 1 | Address strobe, active low |
| data_stb_n | output | 1 | Data strobe, active low |
| rd_wr_n | output | 1 | High = read, low = write |

## Verification
The bench builds the block with SETUP_CLK = 2, AS_CLK = 2 and RECOV_CLK = 2, and keeps the default strobe lengths of 3 and 2 clocks. With these values every phase counter runs over more than one value, so an off-by-one in setup, address-strobe or recovery counting shows up in the measured phase lengths. All four wait-state settings are used for both directions, which exercises data strobes from 2 to 6 clocks. Addresses 0x0000 and 0xFFFF, read-back after writes, and requests raised mid-cycle with a changed wait count cover the boundary and ignore cases.

// File: rtl/xmem_bus_pkg.sv
package xmem_bus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_ASLO  = 3'd2,
    PH_AHOLD = 3'd3,
    PH_GAP   = 3'd4,
    PH_DSLO  = 3'd5,
    PH_DHOLD = 3'd6,
    PH_RECOV = 3'd7
  } phase_e;

  // Data strobe low time in clocks for one direction plus wait states.
  function automatic int unsigned ds_clocks(logic wr, int unsigned ws,
                                            int unsigned t_rd, int unsigned t_wr);
    return (wr ? t_wr : t_rd) + ws;
  endfunction

  // Clocks spent in a given phase.
  function automatic int unsigned phase_len(phase_e p, logic wr, int unsigned ws,
                                            int unsigned t_setup, int unsigned t_as,
                                            int unsigned t_rd, int unsigned t_wr,
                                            int unsigned t_rec);
    case (p)
      PH_SETUP: return t_setup;
      PH_ASLO:  return t_as;
      PH_DSLO:  return ds_clocks(wr, ws, t_rd, t_wr);
      PH_RECOV: return t_rec;
      default:  return 1;
    endcase
  endfunction

  // Phase order of one bus cycle.
  function automatic phase_e next_phase(phase_e p);
    case (p)
      PH_SETUP: return PH_ASLO;
      PH_ASLO:  return PH_AHOLD;
      PH_AHOLD: return PH_GAP;
      PH_GAP:   return PH_DSLO;
      PH_DSLO:  return PH_DHOLD;
      PH_DHOLD: return PH_RECOV;
      default:  return PH_IDLE;
    endcase
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/xmem_bus_seq.sv
module xmem_bus_seq
  import xmem_bus_pkg::*;
#(
  parameter int unsigned WS_W      = 2,
  parameter int unsigned SETUP_CLK = 1,
  parameter int unsigned AS_CLK    = 1,
  parameter int unsigned RD_DS_CLK = 3,
  parameter int unsigned WR_DS_CLK = 2,
  parameter int unsigned RECOV_CLK = 1,
  parameter int unsigned CNT_W     = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            wr_q,
  input  logic [WS_W-1:0] ws_q,
  output phase_e          phase,
  output logic            last
);

  logic [CNT_W-1:0] cnt;
  phase_e           nxt;
  int unsigned      nxt_len;

  assign nxt     = next_phase(phase);
  assign nxt_len = phase_len(nxt, wr_q, 32'(ws_q), SETUP_CLK, AS_CLK,
                             RD_DS_CLK, WR_DS_CLK, RECOV_CLK);
  assign last    = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (phase == PH_IDLE) begin
      if (start) begin
        phase <= PH_SETUP;
        cnt   <= CNT_W'(SETUP_CLK - 1);
      end
    end else if (last) begin
      phase <= nxt;
      cnt   <= CNT_W'(nxt_len - 1);
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/xmem_bus_path.sv
module xmem_bus_path
  import xmem_bus_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned WS_W   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     accept,
  input  logic                     ds_end,
  input  phase_e                   phase,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     req_write,
  input  logic                     req_dmem,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [WS_W-1:0]          wait_cfg,
  input  logic [DATA_W-1:0]        ad_in,
  output logic                     wr_q,
  output logic [WS_W-1:0]          ws_q,
  output logic [ADDR_W-DATA_W-1:0] hi_addr,
  output logic                     data_space,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic                     addr_stb_n,
  output logic                     data_stb_n,
  output logic                     rd_wr_n,
  output logic [DATA_W-1:0]        rdata,
  output logic                     done
);

  logic [ADDR_W-1:0] addr_q;
  logic              dm_q;
  logic [DATA_W-1:0] wd_q;
  logic              addr_phase;
  logic              wdata_phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      wr_q   <= 1'b0;
      dm_q   <= 1'b0;
      wd_q   <= '0;
      ws_q   <= '0;
      rdata  <= '0;
      done   <= 1'b0;
    end else begin
      done <= ds_end;
      if (accept) begin
        addr_q <= req_addr;
        wr_q   <= req_write;
        dm_q   <= req_dmem;
        wd_q   <= req_wdata;
        ws_q   <= wait_cfg;
      end
      if (ds_end && !wr_q) rdata <= ad_in;
    end
  end

  always_comb begin
    addr_phase  = (phase == PH_SETUP) || (phase == PH_ASLO) || (phase == PH_AHOLD);
    wdata_phase = wr_q && ((phase == PH_GAP) || (phase == PH_DSLO) || (phase == PH_DHOLD));
    ad_oe       = addr_phase || wdata_phase;
    ad_out      = addr_phase ? addr_q[DATA_W-1:0] : wd_q;
    addr_stb_n  = (phase != PH_ASLO);
    data_stb_n  = (phase != PH_DSLO);
    rd_wr_n     = !(wr_q && (phase != PH_IDLE));
    hi_addr     = addr_q[ADDR_W-1:DATA_W];
    data_space  = dm_q;
  end

endmodule

// File: rtl/xmem_bus_ctrl.sv
module xmem_bus_ctrl
  import xmem_bus_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned WS_W      = 2,
  parameter int unsigned SETUP_CLK = 1,
  parameter int unsigned AS_CLK    = 1,
  parameter int unsigned RD_DS_CLK = 3,
  parameter int unsigned WR_DS_CLK = 2,
  parameter int unsigned RECOV_CLK = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     req_write,
  input  logic                     req_dmem,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [WS_W-1:0]          wait_cfg,
  output logic                     busy,
  output logic                     done,
  output logic [DATA_W-1:0]        rdata,
  output logic [ADDR_W-DATA_W-1:0] hi_addr,
  output logic                     data_space,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  input  logic [DATA_W-1:0]        ad_in,
  output logic                     addr_stb_n,
  output logic                     data_stb_n,
  output logic                     rd_wr_n
);

  localparam int unsigned WS_MAX  = (1 << WS_W) - 1;
  localparam int unsigned MAX_LEN =
    max2(max2(max2(SETUP_CLK, AS_CLK), RECOV_CLK),
         max2(RD_DS_CLK, WR_DS_CLK) + WS_MAX);
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

  phase_e          phase;
  logic            last;
  logic            wr_q;
  logic [WS_W-1:0] ws_q;

  // named internal events
  logic accept;  // request taken this edge
  logic ds_end;  // data strobe rises at this edge

  assign busy   = (phase != PH_IDLE);
  assign accept = req_valid && !busy;
  assign ds_end = (phase == PH_DSLO) && last;

  xmem_bus_seq #(
    .WS_W(WS_W), .SETUP_CLK(SETUP_CLK), .AS_CLK(AS_CLK),
    .RD_DS_CLK(RD_DS_CLK), .WR_DS_CLK(WR_DS_CLK),
    .RECOV_CLK(RECOV_CLK), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .wr_q(wr_q), .ws_q(ws_q),
    .phase(phase), .last(last)
  );

  xmem_bus_path #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WS_W(WS_W)
  ) u_path (
    .clk(clk), .rst_n(rst_n), .accept(accept), .ds_end(ds_end), .phase(phase),
    .req_addr(req_addr), .req_write(req_write), .req_dmem(req_dmem),
    .req_wdata(req_wdata), .wait_cfg(wait_cfg), .ad_in(ad_in),
    .wr_q(wr_q), .ws_q(ws_q), .hi_addr(hi_addr), .data_space(data_space),
    .ad_out(ad_out), .ad_oe(ad_oe), .addr_stb_n(addr_stb_n),
    .data_stb_n(data_stb_n), .rd_wr_n(rd_wr_n), .rdata(rdata), .done(done)
  );

endmodule

// File: rtl/xmem_bus_ctrl_chk.sv
module xmem_bus_ctrl_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic [ADDR_W-1:0]        req_addr,
  input logic                     accept,
  input logic                     ds_end,
  input logic                     busy,
  input logic                     done,
  input logic [ADDR_W-DATA_W-1:0] hi_addr,
  input logic                     data_space,
  input logic                     ad_oe,
  input logic                     addr_stb_n,
  input logic                     data_stb_n,
  input logic                     rd_wr_n
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (addr_stb_n && data_stb_n && rd_wr_n && !ad_oe && !done));

  // R2
  hi_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (hi_addr == $past(req_addr[ADDR_W-1:DATA_W])));

  // R2
  hi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(hi_addr) && $stable(data_space)));

  // R3
  rw_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(rd_wr_n));

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (addr_stb_n || data_stb_n));

  // R4
  as_rise_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_stb_n) |-> ad_oe);

  // R5
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_stb_n && rd_wr_n) |-> !ad_oe);

  // R6
  wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_stb_n && !rd_wr_n) |-> ad_oe);

  // R5
  done_after_ds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ds_end |=> (data_stb_n && done));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |-> !accept);

endmodule

bind xmem_bus_ctrl xmem_bus_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .accept(accept), .ds_end(ds_end), .busy(busy), .done(done),
  .hi_addr(hi_addr), .data_space(data_space), .ad_oe(ad_oe),
  .addr_stb_n(addr_stb_n), .data_stb_n(data_stb_n), .rd_wr_n(rd_wr_n)
);

// File: tb/xmem_bus_ctrl_test.sv
`timescale 1ns/1ps
module xmem_bus_ctrl_test;

  localparam int T_SETUP = 2;
  localparam int T_AS    = 2;
  localparam int T_RD    = 3;
  localparam int T_WR    = 2;
  localparam int T_REC   = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_dmem = 1'b0;
  logic [7:0]  req_wdata = '0;
  logic [1:0]  wait_cfg = '0;
  logic        busy, done, data_space, ad_oe, addr_stb_n, data_stb_n, rd_wr_n;
  logic [7:0]  rdata, hi_addr, ad_out, ad_in;
  logic [7:0]  rd_val = 8'h00;

  always #2 clk = ~clk;

  xmem_bus_ctrl #(
    .SETUP_CLK(T_SETUP), .AS_CLK(T_AS), .RD_DS_CLK(T_RD),
    .WR_DS_CLK(T_WR), .RECOV_CLK(T_REC)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_dmem(req_dmem), .req_wdata(req_wdata),
    .wait_cfg(wait_cfg), .busy(busy), .done(done), .rdata(rdata),
    .hi_addr(hi_addr), .data_space(data_space), .ad_out(ad_out), .ad_oe(ad_oe),
    .ad_in(ad_in), .addr_stb_n(addr_stb_n), .data_stb_n(data_stb_n),
    .rd_wr_n(rd_wr_n)
  );

  // bus-side memory: drives valid data only while a read strobe is low
  assign ad_in = (!data_stb_n && rd_wr_n) ? rd_val : 8'hEE;

  typedef struct {
    logic [15:0] addr;
    logic        wr;
    logic        dm;
    logic [7:0]  wd;
    int          ws;
    logic [7:0]  exp_rd;
  } item_t;

  item_t      sb_q[$];
  logic [7:0] exp_mem [logic [15:0]];
  logic [7:0] bus_mem [logic [15:0]];
  int n_checks = 0;
  int n_fails  = 0;

  function automatic logic [7:0] pat(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // driver: waits for idle, raises one request, pushes expectation
  task automatic issue(logic [15:0] a, logic wr, logic dm, logic [7:0] wd, int ws);
    item_t it;
    while (busy) begin @(posedge clk); #1; end
    req_addr = a; req_write = wr; req_dmem = dm; req_wdata = wd;
    wait_cfg = 2'(ws); req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    it.addr = a; it.wr = wr; it.dm = dm; it.wd = wd; it.ws = ws;
    if (wr) begin
      exp_mem[a] = wd;
      it.exp_rd = 8'h00;
    end else begin
      it.exp_rd = exp_mem.exists(a) ? exp_mem[a] : pat(a);
    end
    sb_q.push_back(it);
  endtask

  // R9 / R7: raise a different request and change wait_cfg mid-cycle
  task automatic poke_busy();
    repeat (3) begin @(posedge clk); #1; end
    req_addr = ~req_addr; req_write = ~req_write; wait_cfg = ~wait_cfg;
    req_valid = 1'b1;
    repeat (2) begin @(posedge clk); #1; end
    req_valid = 1'b0;
  endtask

  // monitor
  logic p_busy = 0, p_as = 1, p_ds = 1, p_oe = 0;
  logic [7:0] p_out = 0;
  int m_busy = 0, m_setup = 0, m_as = 0, m_ds = 0, m_post = 0, m_pulses = 0, m_done = 0;
  bit as_seen = 0, ds_seen = 0;
  logic [7:0] m_hi = 0, m_lo = 0, m_rd = 0, m_pre_out = 0, m_rise_out = 0;
  logic m_lo_oe = 0, m_dm = 0, m_rw = 0, m_pre_oe = 0, m_rise_oe = 0;
  logic [7:0] last_rd = 8'h00;

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) m_busy++;
      if (busy && addr_stb_n && !as_seen) m_setup++;
      if (!addr_stb_n) begin
        as_seen = 1;
        m_as++;
        if (p_as) m_pulses++;
      end
      if (addr_stb_n && !p_as) begin
        m_hi = hi_addr; m_lo = ad_out; m_lo_oe = ad_oe; m_dm = data_space; m_rw = rd_wr_n;
        rd_val = bus_mem.exists({hi_addr, ad_out}) ? bus_mem[{hi_addr, ad_out}]
                                                   : pat({hi_addr, ad_out});
      end
      if (!data_stb_n) begin
        m_ds++;
        if (p_ds) begin m_pre_oe = p_oe; m_pre_out = p_out; end
      end
      if (data_stb_n && !p_ds) begin
        ds_seen = 1;
        m_rise_oe = ad_oe; m_rise_out = ad_out;
        if (!rd_wr_n) bus_mem[{m_hi, m_lo}] = ad_out;
      end
      if (busy && ds_seen) m_post++;
      if (done) begin m_done++; m_rd = rdata; end
      if (!busy && p_busy) begin
        item_t it;
        int exp_ds;
        if (sb_q.size() == 0) begin
          check(0, "R9", "cycle without request", 1, 0);
        end else begin
          it = sb_q.pop_front();
          exp_ds = (it.wr ? T_WR : T_RD) + it.ws;
          check({m_hi, m_lo} == it.addr && m_lo_oe, "R2", "address at AS rise", {m_hi, m_lo}, it.addr);
          check(m_dm == it.dm, "R2", "space select", m_dm, it.dm);
          check(m_rw == !it.wr, "R3", "rd_wr_n level", m_rw, !it.wr);
          check(m_setup == T_SETUP, "R3", "setup clocks", m_setup, T_SETUP);
          check(m_as == T_AS, "R3", "address strobe clocks", m_as, T_AS);
          check(m_pulses == 1, "R9", "address strobe pulses", m_pulses, 1);
          check(m_ds == exp_ds, "R7", "data strobe clocks", m_ds, exp_ds);
          check(m_post == 1 + T_REC, "R8", "clocks after DS rise", m_post, 1 + T_REC);
          check(m_busy == T_SETUP + T_AS + 3 + exp_ds + T_REC, "R8", "busy clocks",
                m_busy, T_SETUP + T_AS + 3 + exp_ds + T_REC);
          check(m_done == 1, "R5", "done pulses", m_done, 1);
          if (it.wr) begin
            check(m_pre_oe && m_pre_out == it.wd, "R4", "write byte before DS fall", m_pre_out, it.wd);
            check(m_rise_oe && m_rise_out == it.wd, "R6", "write byte after DS rise", m_rise_out, it.wd);
            check(rdata == last_rd, "R6", "rdata kept on write", rdata, last_rd);
          end else begin
            check(!m_pre_oe, "R4", "bus released before DS fall", m_pre_oe, 0);
            check(!m_rise_oe, "R5", "bus released at DS rise", m_rise_oe, 0);
            check(m_rd == it.exp_rd, "R5", "read data", m_rd, it.exp_rd);
            last_rd = it.exp_rd;
          end
        end
        m_busy = 0; m_setup = 0; m_as = 0; m_ds = 0; m_post = 0; m_pulses = 0; m_done = 0;
        as_seen = 0; ds_seen = 0;
      end
      p_busy = busy; p_as = addr_stb_n; p_ds = data_stb_n; p_oe = ad_oe; p_out = ad_out;
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    check(addr_stb_n && data_stb_n, "R1", "strobes after reset", {addr_stb_n, data_stb_n}, 3);
    check(rd_wr_n && !ad_oe, "R1", "rw/oe after reset", {rd_wr_n, ad_oe}, 2);
    check(!busy && !done, "R1", "busy/done after reset", {busy, done}, 0);
    @(posedge clk); #1;

    for (int w = 0; w < 4; w++) issue(16'h1234 + 16'(w), 1'b0, 1'(w), 8'h00, w);
    for (int w = 0; w < 4; w++) issue(16'h8100 + 16'(w), 1'b1, 1'(w + 1), 8'hC0 + 8'(w), w);
    issue(16'h0000, 1'b1, 1'b1, 8'hA5, 0);
    issue(16'hFFFF, 1'b1, 1'b0, 8'h3C, 3);
    issue(16'h0000, 1'b0, 1'b1, 8'h00, 1);
    issue(16'hFFFF, 1'b0, 1'b0, 8'h00, 2);
    for (int w = 0; w < 4; w++) issue(16'h8100 + 16'(w), 1'b0, 1'b1, 8'h00, 3 - w);
    // R9 and R7: mid-cycle requests and wait changes ignored
    issue(16'h4242, 1'b0, 1'b0, 8'h00, 0);
    poke_busy();
    issue(16'h5151, 1'b1, 1'b1, 8'h77, 1);
    poke_busy();
    issue(16'h5151, 1'b0, 1'b1, 8'h00, 2);
    for (int k = 0; k < 16; k++)
      issue(16'(k * 16'h1357), 1'(k % 3 == 0), 1'(k % 2), 8'(k * 29), k % 4);

    while (busy || sb_q.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
    summary();
    $finish;
  end

endmodule